// File: doc/BRIEF.md
# JESD204 Transport Layer Deframer

This block sits between the link layer and the application on the receive side of a JESD204 link. Each clock beat it takes a fixed number of octets from every lane, already code-group aligned and lane aligned. It cuts the beat into frames and slices every frame into converter samples. The samples come out on one wide parallel bus, registered once, beside a valid flag that is always high and a per-channel enable.

The lane count L, converter count M, samples per frame S, resolution N, bits per sample NP and octets per lane per beat are parameters. The octets per frame, F = M*S*NP/(8*L), follow from them. Elaboration stops with an error if F is not 1, 2 or 4, if L*8*F differs from M*S*NP, or if F does not divide the octets per beat. The whole datapath runs in the link clock domain. That clock is the line rate divided by 40 for 8b/10b links and by 66 for 64b/66b links.

Top module: `jtl_deframer`

## Requirements
- R1: In the cycle after an edge that samples `rst` high, `smp_data` and `smp_en` are all zeros.
- R2: `smp_valid` is 1 in every cycle, during reset as well.
- R3: Outputs change only on the clock edge after the input they depend on, so the path has exactly one register stage.
- R4: Lane l sits at bits [l*OPB*8 +: OPB*8] of `lane_data`. Inside a lane, octet o sits at bits [o*8 +: 8], and octet 0 is the earliest. Frame f of a beat is made of lane octets f*F to f*F+F-1.
- R5: The bit stream of a frame is lane 0's F octets, then lane 1's, and so on, with each octet sent MSB first. Sample t = c*S+s of the frame (converter c, sample s) takes stream bits t*NP to t*NP+NP-1, and the first of these is the most significant.
- R6: On `smp_data`, the N-bit slot with index c*S*FPB + f*S + s holds converter c, sample s of frame f, where FPB = OPB/F. Slot 0 sits at the LSB, so all of converter 0's samples come before converter 1's.
- R7: When NP > N, a result is the top N bits of its NP-bit sample. The low NP-N bits are dropped.
- R8: Configurations with F = 2 and F = 4 are repacked into the same layout as F = 1.
- R9: Bit m of `smp_en` equals bit m of `chan_en` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | L*OPB*8 | Lane-aligned link data, one beat per cycle |
| chan_en | input | M | Channel enables from software |
| smp_valid | output | 1 | Sample qualifier, always 1 |
| smp_data | output | M*S*FPB*N | Concatenated converter samples |
| smp_en | output | M | Registered channel enables |

## Verification
The assertions check on every cycle that the output is cleared after reset and that a steady input gives a steady output one edge later. They also check that the enables track the input with a one-cycle delay. Two further checks hold on every cycle: the frame slicer only moves octets without changing any bit (its population count is unchanged), and the sample mapper never adds set bits when it drops tail bits. Only the bench scenarios can show that each octet and sample lands in its exact slot for every frame size. It compares three configurations (F of 1, 2 and 4, two of them with NP > N) against a bit-by-bit reference built from the requirements.

// File: rtl/jtl_pkg.sv
package jtl_pkg;

  // octets per frame derived from the link parameters (0 if not exact)
  function automatic int oct_per_frame(input int l, input int m, input int s, input int np);
    if (l <= 0 || (m * s * np) % (8 * l) != 0) return 0;
    return (m * s * np) / (8 * l);
  endfunction

  // F value safe for use as a divisor
  function automatic int safe_frame(input int l, input int m, input int s, input int np);
    int f;
    f = oct_per_frame(l, m, s, np);
    return (f == 0) ? 1 : f;
  endfunction

  function automatic int frames_per_beat(input int opb, input int f);
    return (opb / f == 0) ? 1 : opb / f;
  endfunction

  function automatic int out_width(input int l, input int m, input int s, input int n,
                                   input int np, input int opb);
    return m * s * frames_per_beat(opb, safe_frame(l, m, s, np)) * n;
  endfunction

endpackage

// File: rtl/jtl_frame_slicer.sv
// Regroups one beat of lane octets into frames, each held MSB-first as a
// single stream word (R4, R5).
module jtl_frame_slicer #(
  parameter int L   = 4,
  parameter int OPB = 4,
  parameter int F   = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [L*OPB*8-1:0]         beat,
  output logic [(OPB/F)*L*F*8-1:0]   frames
);
  localparam int FPB  = OPB / F;
  localparam int LW   = OPB * 8;
  localparam int FB   = L * F * 8;

  for (genvar f = 0; f < FPB; f++) begin : g_frame
    for (genvar l = 0; l < L; l++) begin : g_lane
      for (genvar o = 0; o < F; o++) begin : g_oct
        // stream octet index j = l*F + o, placed from the top of the frame
        assign frames[f*FB + FB - 1 - 8*(l*F + o) -: 8] = beat[l*LW + (f*F + o)*8 +: 8];
      end
    end
  end

  // R4: the slicer only permutes octets, so no bit is created or lost
  assert_octet_perm_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(beat) == $countones(frames));

endmodule

// File: rtl/jtl_sample_mapper.sv
// Cuts frames into NP-bit samples, keeps the top N bits of each, and places
// them converter-major, sample-minor (R5, R6, R7).
module jtl_sample_mapper #(
  parameter int M   = 2,
  parameter int S   = 1,
  parameter int N   = 16,
  parameter int NP  = 16,
  parameter int FPB = 4,
  parameter int FB  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FPB*FB-1:0]      frames,
  output logic [M*S*FPB*N-1:0]   samples
);
  localparam int SPC = S * FPB;   // samples per converter per beat

  for (genvar f = 0; f < FPB; f++) begin : g_frame
    for (genvar c = 0; c < M; c++) begin : g_conv
      for (genvar s = 0; s < S; s++) begin : g_smp
        localparam int T = c * S + s;
        // top N bits of sample T; low NP-N tail bits are skipped
        assign samples[(c*SPC + f*S + s)*N +: N] = frames[f*FB + FB - 1 - T*NP -: N];
      end
    end
  end

  // R7: dropping tail bits can only remove set bits, never add them
  assert_tail_drop_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(samples) <= $countones(frames));

endmodule

// File: rtl/jtl_deframer.sv
module jtl_deframer import jtl_pkg::*; #(
  parameter int L   = 4,
  parameter int M   = 2,
  parameter int S   = 1,
  parameter int N   = 16,
  parameter int NP  = 16,
  parameter int OPB = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [L*OPB*8-1:0]                     lane_data,
  input  logic [M-1:0]                           chan_en,
  output logic                                   smp_valid,
  output logic [out_width(L,M,S,N,NP,OPB)-1:0]   smp_data,
  output logic [M-1:0]                           smp_en
);
  localparam int F_RAW = oct_per_frame(L, M, S, NP);
  localparam int F     = safe_frame(L, M, S, NP);
  localparam int FPB   = frames_per_beat(OPB, F);
  localparam int FB    = L * F * 8;
  localparam int OW    = out_width(L, M, S, N, NP, OPB);

  // elaboration guards on the frame geometry
  if (L * 8 * F_RAW != M * S * NP) begin : g_bad_geometry
    $error("jtl_deframer: L*8*F must equal M*S*NP");
  end
  if (F_RAW != 1 && F_RAW != 2 && F_RAW != 4) begin : g_bad_f
    $error("jtl_deframer: octets per frame must be 1, 2 or 4");
  end
  if (OPB % F != 0) begin : g_bad_opb
    $error("jtl_deframer: octets per beat must be a multiple of F");
  end
  if (N > NP) begin : g_bad_n
    $error("jtl_deframer: resolution cannot exceed bits per sample");
  end

  logic [FPB*FB-1:0] frames;
  logic [OW-1:0]     mapped;

  jtl_frame_slicer #(.L(L), .OPB(OPB), .F(F)) u_slicer (
    .clk    (clk),
    .rst    (rst),
    .beat   (lane_data),
    .frames (frames)
  );

  jtl_sample_mapper #(.M(M), .S(S), .N(N), .NP(NP), .FPB(FPB), .FB(FB)) u_mapper (
    .clk     (clk),
    .rst     (rst),
    .frames  (frames),
    .samples (mapped)
  );

  // single output register stage (R3)
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_data <= '0;
      smp_en   <= '0;
    end else begin
      smp_data <= mapped;
      smp_en   <= chan_en;
    end
  end

  assign smp_valid = 1'b1;

  // R1: outputs are cleared after a reset edge
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (smp_data == '0 && smp_en == '0));

  // R3: a steady input yields a steady output one edge later
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(lane_data)) |=> $stable(smp_data));

  // R9: enables follow the input with one cycle of delay
  assert_enable_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (smp_en == $past(chan_en)));

endmodule

// File: tb/sim_jtl_deframer.sv
module sim_jtl_deframer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  // u0: default (F=1); u1: L=1,M=1,S=1,N=12,NP=16 (F=2); u2: L=1,M=1,S=2,N=14,NP=16 (F=4)
  logic [127:0] lane0 = '0;
  logic [1:0]   en0   = '0;
  logic [31:0]  lane1 = '0;
  logic [31:0]  lane2 = '0;
  logic [0:0]   en1   = '0;
  logic         v0, v1, v2;
  logic [127:0] d0;
  logic [1:0]   e0;
  logic [23:0]  d1;
  logic [27:0]  d2;
  logic [0:0]   e1, e2;

  jtl_deframer u0 (.clk(clk), .rst(rst), .lane_data(lane0), .chan_en(en0),
                   .smp_valid(v0), .smp_data(d0), .smp_en(e0));
  jtl_deframer #(.L(1), .M(1), .S(1), .N(12), .NP(16), .OPB(4)) u1 (
    .clk(clk), .rst(rst), .lane_data(lane1), .chan_en(en1),
    .smp_valid(v1), .smp_data(d1), .smp_en(e1));
  jtl_deframer #(.L(1), .M(1), .S(2), .N(14), .NP(16), .OPB(4)) u2 (
    .clk(clk), .rst(rst), .lane_data(lane2), .chan_en(en1),
    .smp_valid(v2), .smp_data(d2), .smp_en(e2));

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [127:0] x0;
    logic [1:0]   xe;
    logic [23:0]  x1;
    logic [27:0]  x2;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bit-level reference built from R4..R7
  function automatic logic [127:0] model(input logic [127:0] din, input int l, input int m,
                                         input int s, input int n, input int np, input int opb);
    logic [127:0] r = '0;
    int f  = (m * s * np) / (8 * l);
    int fp = opb / f;
    for (int c = 0; c < m; c++) begin
      for (int k = 0; k < s * fp; k++) begin
        int fr   = k / s;
        int t    = c * s + (k % s);
        int slot = c * s * fp + k;
        for (int b = 0; b < n; b++) begin
          int p    = t * np + b;
          int j    = p / 8;
          int lane = j / f;
          int oct  = fr * f + (j % f);
          r[slot * n + (n - 1 - b)] = din[lane * opb * 8 + oct * 8 + (7 - p % 8)];
        end
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [127:0] din, input logic [1:0] en);
    exp_t e;
    logic [127:0] t1, t2;
    @(negedge clk);
    lane0 = din;
    en0   = en;
    lane1 = din[31:0];
    lane2 = din[63:32];
    en1   = en[0];
    t1 = model({96'd0, din[31:0]}, 1, 1, 1, 12, 16, 4);
    t2 = model({96'd0, din[63:32]}, 1, 1, 2, 14, 16, 4);
    e.x0 = model(din, 4, 2, 1, 16, 16, 4);
    e.xe = en;
    e.x1 = t1[23:0];
    e.x2 = t2[27:0];
    q.push_back(e);
  endtask

  // monitor: one result per edge, one cycle after the drive (R3)
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      check(d0 === e.x0, "R3/R4/R5/R6 u0 data", d0, e.x0);
      check(e0 === e.xe, "R9 u0 enable", {126'd0, e0}, {126'd0, e.xe});
      check(d1 === e.x1, "R7/R8 u1 F=2 data", {104'd0, d1}, {104'd0, e.x1});
      check(d2 === e.x2, "R7/R8 u2 F=4 data", {100'd0, d2}, {100'd0, e.x2});
      check(e1 === e.xe[0], "R9 u1 enable", {127'd0, e1}, {127'd0, e.xe[0]});
      check(v0 && v1 && v2, "R2 valid", {125'd0, v0, v1, v2}, 128'd7);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    repeat (3) @(posedge clk);
    #1;
    check(d0 == '0 && e0 == '0, "R1 reset u0", d0, 128'd0);
    check(d1 == '0 && d2 == '0, "R1 reset u1/u2", {d1, d2}, 128'd0);
    check(v0 && v1 && v2, "R2 valid in reset", {125'd0, v0, v1, v2}, 128'd7);
    @(negedge clk);
    rst = 1'b0;

    // labelled octets: {lane, octet index}
    for (int l = 0; l < 4; l++)
      for (int o = 0; o < 4; o++)
        pat[l*32 + o*8 +: 8] = 8'((l << 4) | o);
    drive(pat, 2'b01);
    drive('0, 2'b10);
    drive({128{1'b1}}, 2'b11);
    for (int i = 0; i < 128; i += 9) drive(128'd1 << i, 2'(i));
    for (int i = 0; i < 40; i++)
      drive({$urandom, $urandom, $urandom, $urandom}, 2'($urandom));
    drive(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 2'b00);
    repeat (3) @(posedge clk);

    // reset mid-run with busy inputs
    @(negedge clk);
    lane0 = {128{1'b1}};
    lane1 = '1;
    lane2 = '1;
    en0 = 2'b11;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(d0 == '0 && e0 == '0, "R1 reset after traffic", d0, 128'd0);
    check(d1 == '0 && d2 == '0, "R1 reset after traffic u1/u2", {d1, d2}, 128'd0);
    check(v0, "R2 valid during reset", {127'd0, v0}, 128'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule